// File: doc/BRIEF.md
# Output Load-Detect Sequencer

This block runs a termination check on each of four DAC current outputs. It drives an external detection comparator through a 2-bit channel-select bus and an active-low precharge strobe. It then reads the comparator's single result bit. A one-cycle start request begins a scan, which visits physical outputs 0, 1, 2 and 3 in turn.

For each output the block places the select code and holds the strobe high for a setup interval. It then pulls the strobe low. Once the comparator settling time has passed, it samples the comparator near the end of the low phase and raises the strobe again. When the fourth output has been evaluated, the block publishes a 4-bit load-present vector together with a one-cycle done pulse.

All intervals are given in nanoseconds as parameters. They are converted to clock cycles from the clock period by rounding up.

Top module: `ld_scan_ctrl`

## Requirements
- R1: While reset is held, the strobe is high, done is low, the load vector is 0000 and the select code is 00.
- R2: A scan visits physical outputs 0, 1, 2, 3 in that order, using select codes 00, 10, 01, 11 respectively (code = {output[0], output[1]}).
- R3: The select code stays unchanged for at least SETUP_CYC cycles before the strobe falls.
- R4: The strobe stays low for exactly LOW_CYC = max(low-width cycles, settle cycles) cycles, and the select code does not change while it is low.
- R5: The comparator is sampled once per output, in the last low cycle of the strobe, which is no earlier than the settling delay after the fall.
- R6: Bit i of the load vector is the comparator level sampled for physical output i: 1 means a load is present and 0 means no load.
- R7: Done is a one-cycle pulse. It rises exactly 4*(SETUP_CYC+LOW_CYC) cycles after the edge that accepts start. The load vector changes only together with done.
- R8: A start request during a scan has no effect. A start in the done cycle or while idle begins a new scan.
- R9: The strobe is high whenever no scan is in progress.
- R10: Each cycle count equals ceil(ns*1000/CLK_PERIOD_PS), and is at least 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scan_start | input | 1 | Request to begin a scan of all four outputs |
| cmp_in | input | 1 | Comparator result, high = load present |
| chan_sel | output | 2 | Select code for the output under test |
| pre_n | output | 1 | Active-low precharge strobe to the comparator |
| load_present | output | 4 | Per-output load result, indexed by physical output |
| scan_done | output | 1 | One-cycle pulse when the vector is updated |

## Verification
A wrong channel counter shows at the ports as a select code out of order, or as a result bit landing in the wrong position of the vector. The select code is visible at the very next strobe fall. A bad result bit shows when done pulses at the end of the scan.

A timer or state fault stretches or shortens a strobe phase, which is visible within one channel slot. It also moves the done pulse away from its fixed cycle. A comparator model that returns the wrong value before the settling delay exposes any sample taken too early in the same scan.

// File: rtl/ld_scan_pkg.sv
package ld_scan_pkg;

    localparam int unsigned NUM_OUT = 4;

    typedef logic [1:0] sel_code_t;
    typedef logic [1:0] out_idx_t;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_SETUP = 2'd1,
        ST_LOW   = 2'd2
    } scan_state_e;

    // One comparator sample request from the sequencer to the result store
    typedef struct packed {
        logic     sample;
        logic     publish;
        out_idx_t idx;
    } sample_cmd_t;

    // Round a nanosecond interval up to whole clock cycles, never below one
    function automatic int unsigned ns_to_cycles(input int unsigned ns,
                                                 input int unsigned period_ps);
        int unsigned c;
        c = (ns * 1000 + period_ps - 1) / period_ps;
        if (c == 0) c = 1;
        return c;
    endfunction

    function automatic int unsigned max_u(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

    // The comparator mux decodes the select bits swapped relative to output number
    function automatic sel_code_t out_to_sel(input out_idx_t idx);
        return {idx[0], idx[1]};
    endfunction

endpackage

// File: rtl/ld_step_timer.sv
module ld_step_timer #(
    parameter int unsigned CW = 5
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    output logic          expired
);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= load_val;
        end else if (cnt != '0) begin
            cnt <= cnt - 1'b1;
        end
    end

    assign expired = (cnt == '0);

    // Phase lengths depend on a strict one-per-cycle countdown
    assert_count_down_R7: assert property (@(posedge clk) disable iff (rst)
        (!load && !expired) |=> (cnt == $past(cnt) - 1'b1));

    assert_load_value_R10: assert property (@(posedge clk) disable iff (rst)
        load |=> (cnt == $past(load_val)));

endmodule

// File: rtl/ld_scan_fsm.sv
module ld_scan_fsm
    import ld_scan_pkg::*;
#(
    parameter int unsigned SETUP_CYC = 10,
    parameter int unsigned LOW_CYC   = 20,
    parameter int unsigned CW        = 5
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  logic          tmr_expired,
    output logic          tmr_load,
    output logic [CW-1:0] tmr_val,
    output sel_code_t     chan_sel,
    output logic          pre_n,
    output sample_cmd_t   cmd,
    output logic          done
);

    localparam logic [CW-1:0] SETUP_LD = CW'(SETUP_CYC - 1);
    localparam logic [CW-1:0] LOW_LD   = CW'(LOW_CYC - 1);
    localparam out_idx_t      LAST_IDX = out_idx_t'(NUM_OUT - 1);

    scan_state_e state, state_n;
    out_idx_t    ch, ch_n;
    logic        done_n;

    always_comb begin
        state_n  = state;
        ch_n     = ch;
        tmr_load = 1'b0;
        tmr_val  = '0;
        cmd      = '0;
        done_n   = 1'b0;
        case (state)
            ST_IDLE: begin
                if (start) begin
                    state_n  = ST_SETUP;
                    ch_n     = '0;
                    tmr_load = 1'b1;
                    tmr_val  = SETUP_LD;
                end
            end
            ST_SETUP: begin
                if (tmr_expired) begin
                    state_n  = ST_LOW;
                    tmr_load = 1'b1;
                    tmr_val  = LOW_LD;
                end
            end
            ST_LOW: begin
                if (tmr_expired) begin
                    cmd.sample = 1'b1;
                    cmd.idx    = ch;
                    if (ch == LAST_IDX) begin
                        state_n     = ST_IDLE;
                        cmd.publish = 1'b1;
                        done_n      = 1'b1;
                    end else begin
                        state_n  = ST_SETUP;
                        ch_n     = ch + 1'b1;
                        tmr_load = 1'b1;
                        tmr_val  = SETUP_LD;
                    end
                end
            end
            default: state_n = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ST_IDLE;
            ch       <= '0;
            chan_sel <= '0;
            pre_n    <= 1'b1;
            done     <= 1'b0;
        end else begin
            state    <= state_n;
            ch       <= ch_n;
            chan_sel <= out_to_sel(ch_n);
            pre_n    <= (state_n != ST_LOW);
            done     <= done_n;
        end
    end

    assert_idle_strobe_high_R9: assert property (@(posedge clk) disable iff (rst)
        (state == ST_IDLE) |-> pre_n);

    assert_sel_steady_low_R4: assert property (@(posedge clk) disable iff (rst)
        !pre_n |=> (pre_n || $stable(chan_sel)));

    assert_done_single_R7: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    assert_start_ignored_R8: assert property (@(posedge clk) disable iff (rst)
        (state == ST_SETUP && start && !tmr_expired) |=> (state == ST_SETUP && $stable(ch)));

endmodule

// File: rtl/ld_result_acc.sv
module ld_result_acc
    import ld_scan_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  sample_cmd_t        cmd,
    input  logic               cmp_bit,
    output logic [NUM_OUT-1:0] present
);

    logic [NUM_OUT-1:0] shadow, shadow_n;

    always_comb begin
        shadow_n = shadow;
        if (cmd.sample) shadow_n[cmd.idx] = cmp_bit;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            shadow  <= '0;
            present <= '0;
        end else begin
            shadow <= shadow_n;
            if (cmd.publish) present <= shadow_n;
        end
    end

    assert_publish_last_R7: assert property (@(posedge clk) disable iff (rst)
        cmd.publish |-> (cmd.sample && cmd.idx == out_idx_t'(NUM_OUT - 1)));

    assert_vector_holds_R7: assert property (@(posedge clk) disable iff (rst)
        !cmd.publish |=> $stable(present));

endmodule

// File: rtl/ld_scan_ctrl.sv
module ld_scan_ctrl
    import ld_scan_pkg::*;
#(
    parameter int unsigned CLK_PERIOD_PS = 10000,
    parameter int unsigned SETUP_NS      = 100,
    parameter int unsigned LOW_NS        = 200,
    parameter int unsigned SETTLE_NS     = 100
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        scan_start,
    input  logic        cmp_in,
    output logic [1:0]  chan_sel,
    output logic        pre_n,
    output logic [3:0]  load_present,
    output logic        scan_done
);

    localparam int unsigned SETUP_CYC  = ns_to_cycles(SETUP_NS, CLK_PERIOD_PS);
    localparam int unsigned SETTLE_CYC = ns_to_cycles(SETTLE_NS, CLK_PERIOD_PS);
    localparam int unsigned LOW_CYC    = max_u(ns_to_cycles(LOW_NS, CLK_PERIOD_PS), SETTLE_CYC);
    localparam int unsigned CW         = $clog2(max_u(SETUP_CYC, LOW_CYC) + 1);
    localparam int unsigned AW         = CW + 1;

    logic          tmr_load;
    logic [CW-1:0] tmr_val;
    logic          tmr_expired;
    sample_cmd_t   cmd;

    ld_step_timer #(.CW(CW)) u_timer (
        .clk      (clk),
        .rst      (rst),
        .load     (tmr_load),
        .load_val (tmr_val),
        .expired  (tmr_expired)
    );

    ld_scan_fsm #(
        .SETUP_CYC (SETUP_CYC),
        .LOW_CYC   (LOW_CYC),
        .CW        (CW)
    ) u_fsm (
        .clk         (clk),
        .rst         (rst),
        .start       (scan_start),
        .tmr_expired (tmr_expired),
        .tmr_load    (tmr_load),
        .tmr_val     (tmr_val),
        .chan_sel    (chan_sel),
        .pre_n       (pre_n),
        .cmd         (cmd),
        .done        (scan_done)
    );

    ld_result_acc u_acc (
        .clk     (clk),
        .rst     (rst),
        .cmd     (cmd),
        .cmp_bit (cmp_in),
        .present (load_present)
    );

    // Window counters for the strobe timing checks
    logic [AW-1:0] low_len;
    logic [AW-1:0] sel_age;
    logic [1:0]    sel_prev;

    always_ff @(posedge clk) begin
        if (rst) begin
            low_len  <= '0;
            sel_age  <= '0;
            sel_prev <= '0;
        end else begin
            low_len  <= pre_n ? '0 : ((low_len == '1) ? low_len : low_len + 1'b1);
            sel_prev <= chan_sel;
            if (chan_sel != sel_prev)  sel_age <= '0;
            else if (sel_age != '1)    sel_age <= sel_age + 1'b1;
        end
    end

    // At the sampled fall, sel_age counts the stable cycles after the first one
    assert_sel_setup_R3: assert property (@(posedge clk) disable iff (rst)
        $fell(pre_n) |-> (sel_age >= AW'(SETUP_CYC - 1)));

    assert_low_width_R4: assert property (@(posedge clk) disable iff (rst)
        $rose(pre_n) |-> (low_len == AW'(LOW_CYC)));

endmodule

// File: tb/ld_scan_ctrl_tb_top.sv
module ld_scan_ctrl_tb_top;

    localparam int PER_PS = 10000;
    localparam int S_NS   = 95;
    localparam int L_NS   = 195;
    localparam int E_NS   = 91;
    localparam int S_CYC  = (S_NS * 1000 + PER_PS - 1) / PER_PS;
    localparam int E_CYC  = (E_NS * 1000 + PER_PS - 1) / PER_PS;
    localparam int L_RAW  = (L_NS * 1000 + PER_PS - 1) / PER_PS;
    localparam int L_CYC  = (L_RAW > E_CYC) ? L_RAW : E_CYC;
    localparam int SCAN_N = 4 * (S_CYC + L_CYC) + 1;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       scan_start = 1'b0;
    logic       cmp_in;
    logic [1:0] chan_sel;
    logic       pre_n;
    logic [3:0] load_present;
    logic       scan_done;

    always #5 clk = ~clk;

    ld_scan_ctrl #(
        .CLK_PERIOD_PS (PER_PS),
        .SETUP_NS      (S_NS),
        .LOW_NS        (L_NS),
        .SETTLE_NS     (E_NS)
    ) dut_i (
        .clk          (clk),
        .rst          (rst),
        .scan_start   (scan_start),
        .cmp_in       (cmp_in),
        .chan_sel     (chan_sel),
        .pre_n        (pre_n),
        .load_present (load_present),
        .scan_done    (scan_done)
    );

    int checks = 0;
    int fails  = 0;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Comparator model: correct only after the settling delay, inverted before
    logic [3:0] truth = 4'b0000;
    int         fall_age = 0;

    function automatic int sel_to_out(input logic [1:0] s);
        case (s)
            2'b00:   return 0;
            2'b10:   return 1;
            2'b01:   return 2;
            default: return 3;
        endcase
    endfunction

    always @(posedge clk) begin
        if (pre_n) fall_age <= 0;
        else       fall_age <= fall_age + 1;
    end

    assign cmp_in = (!pre_n && fall_age >= E_CYC) ? truth[sel_to_out(chan_sel)]
                                                  : ~truth[sel_to_out(chan_sel)];

    // Scoreboard queues
    logic [3:0] exp_q[$];
    logic [1:0] sel_exp_q[$];
    logic [3:0] e_vec;
    logic [1:0] e_sel;

    // Monitor
    bit         mon_en = 1'b0;
    logic       prev_pre = 1'b1;
    logic       prev_done = 1'b0;
    logic [1:0] prev_sel = 2'b00;
    int         stab = 0;
    int         low_cnt = 0;
    bit         sel_moved = 1'b0;

    always @(negedge clk) begin
        if (mon_en) begin
            if (prev_pre && !pre_n) begin
                if (sel_exp_q.size() == 0) begin
                    chk(1'b0, "R2 unexpected strobe fall", chan_sel, 0);
                end else begin
                    e_sel = sel_exp_q.pop_front();
                    chk(chan_sel == e_sel, "R2 select order", chan_sel, e_sel);
                end
                chk(stab >= S_CYC, "R3 select setup", stab, S_CYC);
                low_cnt   = 0;
                sel_moved = 1'b0;
            end
            if (!pre_n) begin
                low_cnt++;
                if (!prev_pre && chan_sel != prev_sel) sel_moved = 1'b1;
            end
            if (!prev_pre && pre_n) begin
                chk(low_cnt == L_CYC, "R4 R10 strobe low width", low_cnt, L_CYC);
                chk(!sel_moved, "R4 select constant while low", sel_moved, 0);
            end
            if (scan_done) begin
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R7 unexpected done", 1, 0);
                end else begin
                    e_vec = exp_q.pop_front();
                    chk(load_present == e_vec, "R5 R6 load vector", load_present, e_vec);
                end
            end
            if (prev_done) chk(!scan_done, "R7 done width", scan_done, 0);
            if (chan_sel != prev_sel) stab = 1;
            else                      stab++;
            prev_pre  = pre_n;
            prev_done = scan_done;
            prev_sel  = chan_sel;
        end
    end

    // Driver: pushes expectations, launches a scan, measures its length
    task automatic run_scan(input logic [3:0] pat, input bit inject, input bit chained);
        int n;
        truth = pat;
        exp_q.push_back(pat);
        sel_exp_q.push_back(2'b00);
        sel_exp_q.push_back(2'b10);
        sel_exp_q.push_back(2'b01);
        sel_exp_q.push_back(2'b11);
        if (!chained) @(negedge clk);
        scan_start = 1'b1;
        @(negedge clk);
        scan_start = 1'b0;
        n = 1;
        while (!scan_done && n < 1000) begin
            @(negedge clk);
            n++;
            scan_start = (inject && (n == 40 || n == 75));
        end
        scan_start = 1'b0;
        if (inject) chk(n == SCAN_N, "R8 start during scan ignored", n, SCAN_N);
        else        chk(n == SCAN_N, "R7 R10 scan duration", n, SCAN_N);
    endtask

    task automatic idle_watch(input int cycles);
        logic [3:0] hold;
        bit bad;
        hold = load_present;
        bad  = 1'b0;
        repeat (cycles) begin
            @(negedge clk);
            if (!pre_n || scan_done || load_present != hold) bad = 1'b1;
        end
        chk(!bad, "R8 R9 idle strobe high and vector held", bad, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(pre_n == 1'b1,          "R1 reset strobe",  pre_n, 1);
        chk(scan_done == 1'b0,      "R1 reset done",    scan_done, 0);
        chk(load_present == 4'b0,   "R1 reset vector",  load_present, 0);
        chk(chan_sel == 2'b00,      "R1 reset select",  chan_sel, 0);
        rst = 1'b0;
        mon_en = 1'b1;
        idle_watch(5);
        run_scan(4'b0110, 1'b0, 1'b0);
        run_scan(4'b1001, 1'b0, 1'b1);
        run_scan(4'b0000, 1'b0, 1'b1);
        idle_watch(8);
        run_scan(4'b1111, 1'b0, 1'b0);
        run_scan(4'b0101, 1'b1, 1'b0);
        idle_watch(60);
        run_scan(4'b0011, 1'b0, 1'b0);
        run_scan(4'b0100, 1'b0, 1'b1);
        repeat (3) @(negedge clk);
        chk(exp_q.size() == 0,     "R7 all results delivered", exp_q.size(), 0);
        chk(sel_exp_q.size() == 0, "R2 all outputs visited",   sel_exp_q.size(), 0);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog R7 actual=timeout expected=completion");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule